// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block sits between a synchronous request port and an asynchronous DRAM with a multiplexed address bus, 2M words of 8 bits. A request carries a 21-bit word address, a direction flag and, for writes, one byte. The controller splits the address into a row and a column. It activates the row with a RAS strobe and runs a CAS cycle on the column. Read data comes back with a one-cycle valid pulse.

After an access the row stays open. A later request to the same row is served with a column cycle only, and no new row activation. A request to another row closes the page, waits out the precharge and opens the new row. The controller closes a page by itself before the longest allowed RAS-low time runs out. The limit is tighter when the row has served only one access than when it has served a page burst.

Every timing limit is given in nanoseconds and turned into clock counts. Minimums round up and maximums round down. Writes are always early writes, so the data pins are never driven while the output buffer is enabled. A sibling refresh engine asks for the bus with a request/grant pair. It gets the grant only once the row is closed and precharged.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, RAS, CAS, WE and OE outputs are high, the data driver is off, reqReady is 1, and rspValid and refGrant are 0.
- R2: The row is address bits [20:10] and sits on memAddr when RAS falls. The column is address bits [9:0] on memAddr[9:0], with memAddr[10] at 0, and sits on memAddr when CAS falls.
- R3: A read returns the byte of the addressed cell on rspData, together with a rspValid pulse one cycle long.
- R4: On a write, WE is already low when CAS falls and stays unchanged while CAS is low. The data driver is on and OE is high, and the byte on memDqOut is stored at the addressed cell.
- R5: A request to the open row runs a CAS-only cycle, with no new RAS falling edge.
- R6: A request to a different row closes the open row, precharges it and activates the new row with one new RAS falling edge.
- R7: CAS falls at least N_RCD cycles (3 at defaults) after RAS falls.
- R8: Between two CAS cycles on one row, CAS stays high at least N_CP cycles (2 at defaults).
- R9: RAS stays high at least N_RP cycles (5 at defaults) before each falling edge.
- R10: An open row with only one access closes within 1250 cycles of RAS-low. After a page hit, the row closes within 12500 cycles.
- R11: refGrant rises only while RAS and CAS are high and precharge is done. While it is high, reqReady is 0 and no request reaches the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request taken on this edge when reqValid is 1 |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 21 | Word address, row in upper bits |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | One-cycle read response pulse |
| rspData | output | 8 | Read byte |
| refReq | input | 1 | Refresh engine asks for the memory |
| refGrant | output | 1 | Memory handed to the refresh engine |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memAddr | output | 11 | Multiplexed row/column address |
| memDqOut | output | 8 | Write data toward the memory |
| memDqOe | output | 1 | Drive memDqOut onto the data pins |
| memDqIn | input | 8 | Data read from the memory pins |

## Verification
The assertions assume refReq is held until refGrant has been seen and then released by the refresh engine. They also assume the request fields stay stable while reqValid waits for reqReady. The bench holds every request steady until it is taken, raises refReq only from an idle or open-row state, and releases it after a few granted cycles. A behavioural memory model behind the pins stores and returns bytes at the row and column it latches on the strobe edges. The bench counts RAS edges and strobe run lengths from the pins alone.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef struct packed {
    logic rasN;
    logic casN;
    logic weN;
    logic oeN;
    logic selCol;
    logic dqDrive;
    logic capture;
  } fpm_stb_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_COL, S_CASHI, S_OPEN, S_PRE, S_REF
  } fpm_state_t;

  function automatic int cycCeil(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int N_RCD    = 3,
  parameter int N_CASLO  = 5,
  parameter int N_CP     = 2,
  parameter int N_RP     = 5,
  parameter int LIM_RAS  = 1250,
  parameter int LIM_RASP = 12500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [ROW_W-1:0] curRow,
  input  logic             refReq,
  output logic             reqReady,
  output logic             accept,
  output logic             refGrant,
  output fpm_stb_t         stb
);
  localparam int MAXD    = maxOf(maxOf(N_RCD, N_CASLO), maxOf(N_CP, N_RP));
  localparam int CW      = $clog2(MAXD + 1) + 1;
  localparam int RCW     = $clog2(LIM_RASP + 1) + 1;
  localparam int GUARD   = N_CASLO + N_CP + 3;
  localparam int CLOSE_R = LIM_RAS - GUARD;
  localparam int CLOSE_P = LIM_RASP - GUARD;

  fpm_state_t state, nxt;
  logic [CW-1:0]  cnt, cntLoad;
  logic [RCW-1:0] rasCnt;
  logic pending, pageHit, isWrite, rowHit, closeNow, rasLowState;

  assign rowHit      = (reqRow == curRow);
  assign rasLowState = (state == S_ROW) || (state == S_COL) ||
                       (state == S_CASHI) || (state == S_OPEN);
  assign closeNow    = rasCnt >= (pageHit ? RCW'(CLOSE_P) : RCW'(CLOSE_R));
  assign reqReady    = !refReq && ((state == S_IDLE) ||
                                   (state == S_OPEN && !closeNow));
  assign accept      = reqValid && reqReady;
  assign refGrant    = (state == S_REF);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (refReq) nxt = S_REF;
               else if (reqValid) nxt = S_ROW;
      S_ROW:   if (cnt == '0) nxt = S_COL;
      S_COL:   if (cnt == '0) nxt = S_CASHI;
      S_CASHI: if (cnt == '0) nxt = S_OPEN;
      S_OPEN:  if (refReq || closeNow) nxt = S_PRE;
               else if (reqValid) nxt = rowHit ? S_COL : S_PRE;
      S_PRE:   if (cnt == '0) nxt = pending ? S_ROW : S_IDLE;
      S_REF:   if (!refReq) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      S_ROW:   cntLoad = CW'(N_RCD - 1);
      S_COL:   cntLoad = CW'(N_CASLO - 1);
      S_CASHI: cntLoad = CW'(N_CP - 1);
      S_PRE:   cntLoad = CW'(N_RP - 1);
      default: cntLoad = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      rasCnt  <= '0;
      pending <= 1'b0;
      pageHit <= 1'b0;
      isWrite <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state) cnt <= cntLoad;
      else if (cnt != '0) cnt <= cnt - 1'b1;
      rasCnt <= rasLowState ? rasCnt + 1'b1 : '0;
      if (state == S_OPEN && accept && !rowHit) pending <= 1'b1;
      else if (state == S_PRE && nxt == S_ROW) pending <= 1'b0;
      if (nxt == S_ROW) pageHit <= 1'b0;
      else if (state == S_OPEN && nxt == S_COL) pageHit <= 1'b1;
      if (accept) isWrite <= reqWrite;
    end
  end

  always_comb begin
    stb = '{rasN: 1'b1, casN: 1'b1, weN: 1'b1, oeN: 1'b1,
            selCol: 1'b0, dqDrive: 1'b0, capture: 1'b0};
    case (state)
      S_ROW: stb.rasN = 1'b0;
      S_COL: begin
        stb.rasN    = 1'b0;
        stb.casN    = 1'b0;
        stb.selCol  = 1'b1;
        stb.weN     = !isWrite;
        stb.oeN     = isWrite;
        stb.dqDrive = isWrite;
        stb.capture = !isWrite && (cnt == '0);
      end
      S_CASHI: begin
        stb.rasN   = 1'b0;
        stb.selCol = 1'b1;
      end
      S_OPEN:  stb.rasN = 1'b0;
      default: ;
    endcase
  end

endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int DATA_W = 8,
  parameter int PIN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpm_stb_t          stb,
  input  logic              accept,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ROW_W-1:0]  curRow,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [PIN_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] wdReg;
  logic              capD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRow   <= '0;
      colReg   <= '0;
      wdReg    <= '0;
      memRasN  <= 1'b1;
      memCasN  <= 1'b1;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      memAddr  <= '0;
      memDqOut <= '0;
      memDqOe  <= 1'b0;
      capD     <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (accept) begin
        curRow <= reqRow;
        colReg <= reqCol;
        wdReg  <= reqWdata;
      end
      memRasN  <= stb.rasN;
      memCasN  <= stb.casN;
      memWeN   <= stb.weN;
      memOeN   <= stb.oeN;
      memAddr  <= stb.selCol ? PIN_W'(colReg) : PIN_W'(curRow);
      memDqOut <= wdReg;
      memDqOe  <= stb.dqDrive;
      capD     <= stb.capture;
      rspValid <= capD;
      if (capD) rspData <= memDqIn;
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W       = 11,
  parameter int COL_W       = 10,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 8,
  parameter int T_RCD_NS    = 20,
  parameter int T_CAS_NS    = 15,
  parameter int T_ACC_NS    = 35,
  parameter int T_OAC_NS    = 15,
  parameter int T_CP_NS     = 10,
  parameter int T_PC_NS     = 40,
  parameter int T_RP_NS     = 40,
  parameter int T_RC_NS     = 110,
  parameter int T_RAS_MAX   = 10000,
  parameter int T_RASP_MAX  = 100000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [ROW_W+COL_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    rspValid,
  output logic [DATA_W-1:0]       rspData,
  input  logic                    refReq,
  output logic                    refGrant,
  output logic                    memRasN,
  output logic                    memCasN,
  output logic                    memWeN,
  output logic                    memOeN,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] memAddr,
  output logic [DATA_W-1:0]       memDqOut,
  output logic                    memDqOe,
  input  logic [DATA_W-1:0]       memDqIn
);
  localparam int ADDR_W   = ROW_W + COL_W;
  localparam int PIN_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int N_RCD    = cycCeil(T_RCD_NS, CLK_NS);
  localparam int N_CASLO  = maxOf(maxOf(cycCeil(T_CAS_NS, CLK_NS), cycCeil(T_ACC_NS, CLK_NS)),
                                  cycCeil(T_OAC_NS, CLK_NS));
  localparam int N_CP     = maxOf(cycCeil(T_CP_NS, CLK_NS), cycCeil(T_PC_NS, CLK_NS) - N_CASLO);
  localparam int N_RP     = maxOf(cycCeil(T_RP_NS, CLK_NS),
                                  cycCeil(T_RC_NS, CLK_NS) - (N_RCD + N_CASLO + N_CP + 1));
  localparam int LIM_RAS  = T_RAS_MAX / CLK_NS;
  localparam int LIM_RASP = T_RASP_MAX / CLK_NS;

  fpm_stb_t         stb;
  logic             accept;
  logic [ROW_W-1:0] curRow;
  logic [ROW_W-1:0] reqRow;
  logic [COL_W-1:0] reqCol;

  assign reqRow = reqAddr[ADDR_W-1:COL_W];
  assign reqCol = reqAddr[COL_W-1:0];

  fpm_ctrl #(
    .ROW_W(ROW_W), .N_RCD(N_RCD), .N_CASLO(N_CASLO), .N_CP(N_CP),
    .N_RP(N_RP), .LIM_RAS(LIM_RAS), .LIM_RASP(LIM_RASP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRow(reqRow), .curRow(curRow), .refReq(refReq),
    .reqReady(reqReady), .accept(accept), .refGrant(refGrant), .stb(stb)
  );

  fpm_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .PIN_W(PIN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .accept(accept),
    .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata), .memDqIn(memDqIn),
    .curRow(curRow), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memOeN(memOeN), .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
  parameter int N_RCD    = 3,
  parameter int N_CP     = 2,
  parameter int N_RP     = 5,
  parameter int LIM_RASP = 12500
) (
  input logic clk,
  input logic rstN,
  input logic memRasN,
  input logic memCasN,
  input logic memWeN,
  input logic memOeN,
  input logic memDqOe,
  input logic refGrant,
  input logic reqReady,
  input logic rspValid
);
  localparam int W = $clog2(LIM_RASP + 2) + 1;

  logic [W-1:0] rasLowCnt, rasHighCnt, casHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasLowCnt  <= '0;
      rasHighCnt <= W'(N_RP);
      casHighCnt <= W'(N_CP);
    end else begin
      rasLowCnt <= memRasN ? '0 : rasLowCnt + 1'b1;
      if (!memRasN) rasHighCnt <= '0;
      else if (rasHighCnt < W'(N_RP)) rasHighCnt <= rasHighCnt + 1'b1;
      if (!memCasN) casHighCnt <= '0;
      else if (casHighCnt < W'(N_CP)) casHighCnt <= casHighCnt + 1'b1;
    end
  end

  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memRasN) |-> rasHighCnt >= W'(N_RP)); // R9
  AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memCasN) && !memRasN) |-> rasLowCnt >= W'(N_RCD)); // R7
  AST_CAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCasN) |-> casHighCnt >= W'(N_CP)); // R8
  AST_RAS_MAX_LOW: assert property (@(posedge clk) disable iff (!rstN)
    rasLowCnt <= W'(LIM_RASP)); // R10
  AST_WE_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!memCasN && !$past(memCasN)) |-> $stable(memWeN)); // R4
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN); // R4
  AST_GRANT_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    refGrant |-> (memRasN && memCasN)); // R11
  AST_GRANT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    refGrant |-> !reqReady); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R3

endmodule

bind fpm_dram_ctrl fpm_dram_chk #(
  .N_RCD(N_RCD), .N_CP(N_CP), .N_RP(N_RP), .LIM_RASP(LIM_RASP)
) u_chk (
  .clk(clk), .rstN(rstN), .memRasN(memRasN), .memCasN(memCasN),
  .memWeN(memWeN), .memOeN(memOeN), .memDqOe(memDqOe),
  .refGrant(refGrant), .reqReady(reqReady), .rspValid(rspValid)
);

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;
  localparam int E_RCD  = 3;
  localparam int E_CP   = 2;
  localparam int E_RP   = 5;
  localparam int E_RAS  = 10000 / 8;
  localparam int E_RASP = 100000 / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, refReq = 1'b0;
  logic [20:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic reqReady, rspValid, refGrant;
  logic [7:0] rspData;
  logic memRasN, memCasN, memWeN, memOeN, memDqOe;
  logic [10:0] memAddr;
  logic [7:0] memDqOut, memDqIn;

  int tests = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  fpm_dram_ctrl u_fpm_dram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .refReq(refReq), .refGrant(refGrant),
    .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN), .memOeN(memOeN),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory model and pin monitor, sampled away from the active edge
  logic [7:0] mem [int];
  logic [7:0] rdByte = 8'h00;
  logic [10:0] mRow = '0;
  logic prevRas = 1'b1, prevCas = 1'b1, casInRow = 1'b0;
  int rasFalls = 0, lowRun = 0, highRun = 0, casHighRun = 0, maxLow = 0;
  int minRcd = 1000, minCp = 1000, minRp = 1000;

  assign memDqIn = (!memCasN && !memOeN) ? rdByte : 8'h00;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevRas && !memRasN) begin
        mRow = memAddr;
        rasFalls++;
        if (highRun < minRp) minRp = highRun;
      end
      if (prevCas && !memCasN) begin
        int idx;
        if (!memRasN && lowRun < minRcd && !casInRow) minRcd = lowRun;
        if (casInRow && casHighRun < minCp) minCp = casHighRun;
        casInRow = 1'b1;
        check(memAddr[10] == 1'b0, "R2 column bit10", memAddr[10], 0);
        idx = {mRow, memAddr[9:0]};
        if (!memWeN) begin
          check(memDqOe && memOeN, "R4 driver on, OE high", {memDqOe, memOeN}, 3);
          mem[idx] = memDqOut;
        end else begin
          rdByte = mem.exists(idx) ? mem[idx] : 8'hEE;
        end
      end
      if (memRasN) begin
        highRun++; lowRun = 0; casInRow = 1'b0;
      end else begin
        lowRun++; highRun = 0;
        if (lowRun > maxLow) maxLow = lowRun;
      end
      casHighRun = memCasN ? casHighRun + 1 : 0;
    end
    prevRas = memRasN;
    prevCas = memCasN;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      check(1'b0, "watchdog", cycles, 190000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic doReq(input bit wr, input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic readExpect(input logic [20:0] a, input logic [7:0] exp, input string req);
    bit got = 1'b0;
    doReq(1'b0, a, 8'h00);
    for (int i = 0; i < 40 && !got; i++) begin
      if (rspValid) got = 1'b1;
      else @(negedge clk);
    end
    check(got, {req, " response seen"}, got, 1);
    check(rspData == exp, {req, " read data"}, rspData, exp);
    @(negedge clk);
    check(!rspValid, "R3 single-cycle valid", rspValid, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    check(memRasN && memCasN && memWeN && memOeN, "R1 strobes high",
          {memRasN, memCasN, memWeN, memOeN}, 15);
    check(!memDqOe, "R1 driver off", memDqOe, 0);
    check(reqReady, "R1 ready", reqReady, 1);
    check(!rspValid && !refGrant, "R1 valid/grant low", {rspValid, refGrant}, 0);
  endtask

  task automatic testWriteRead();
    logic [20:0] a [4] = '{21'h12345, 21'h1F0001, 21'h000200, 21'h0A57FF};
    logic [7:0]  d [4] = '{8'h3C, 8'hA1, 8'h5E, 8'hF0};
    for (int i = 0; i < 4; i++) begin
      doReq(1'b1, a[i], d[i]);
      idle(14);
      check(mem.exists(int'(a[i])) && mem[int'(a[i])] == d[i], "R2 R4 stored at row/col",
            mem.exists(int'(a[i])) ? mem[int'(a[i])] : -1, d[i]);
    end
    for (int i = 3; i >= 0; i--) readExpect(a[i], d[i], "R3");
  endtask

  task automatic testPageHit();
    int f0;
    doReq(1'b1, 21'h0C840, 8'h77);
    idle(12);
    f0 = rasFalls;
    doReq(1'b1, 21'h0C841, 8'h88);
    readExpect(21'h0C840, 8'h77, "R5");
    readExpect(21'h0C841, 8'h88, "R5");
    check(rasFalls == f0, "R5 no new RAS fall on hit", rasFalls - f0, 0);
  endtask

  task automatic testRowMiss();
    int f0 = rasFalls;
    readExpect(21'h12345, 8'h3C, "R6");
    check(rasFalls == f0 + 1, "R6 one RAS fall on miss", rasFalls - f0, 1);
    check(minRcd >= E_RCD, "R7 RAS to CAS cycles", minRcd, E_RCD);
    check(minCp >= E_CP, "R8 CAS precharge cycles", minCp, E_CP);
    check(minRp >= E_RP, "R9 RAS precharge cycles", minRp, E_RP);
  endtask

  task automatic testRasMaxSingle();
    readExpect(21'h1F0001, 8'hA1, "R10");
    maxLow = lowRun;
    idle(E_RAS + 100);
    check(maxLow <= E_RAS, "R10 single-access close", maxLow, E_RAS);
    check(maxLow > E_RAS - 100, "R10 row held open", maxLow, E_RAS - 100);
    check(memRasN, "R10 RAS high after limit", memRasN, 1);
  endtask

  task automatic testRasMaxPage();
    readExpect(21'h000200, 8'h5E, "R10");
    readExpect(21'h000200, 8'h5E, "R10");
    maxLow = lowRun;
    idle(E_RASP + 100);
    check(maxLow <= E_RASP, "R10 page close", maxLow, E_RASP);
    check(maxLow > E_RAS, "R10 page limit used", maxLow, E_RAS);
    check(memRasN, "R10 RAS high after page limit", memRasN, 1);
  endtask

  task automatic testRefresh();
    bit got = 1'b0;
    int f0;
    readExpect(21'h0A57FF, 8'hF0, "R11");
    @(negedge clk);
    refReq = 1'b1;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (refGrant) got = 1'b1;
    end
    check(got, "R11 grant seen", got, 1);
    check(memRasN && memCasN, "R11 strobes high at grant", {memRasN, memCasN}, 3);
    check(highRun >= E_RP, "R11 precharge done at grant", highRun, E_RP);
    f0 = rasFalls;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 21'h12345;
    for (int i = 0; i < 10; i++) begin
      check(!reqReady, "R11 not ready during grant", reqReady, 0);
      @(negedge clk);
    end
    check(rasFalls == f0, "R11 request held off", rasFalls - f0, 0);
    refReq = 1'b0;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 40 && !got; i++) begin
      if (rspValid) got = 1'b1;
      else @(negedge clk);
    end
    check(got && rspData == 8'h3C, "R11 served after release", rspData, 8'h3C);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset();
    testWriteRead();
    testPageHit();
    testRowMiss();
    testRasMaxSingle();
    testRasMaxPage();
    testRefresh();
    idle(5);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule